// File: doc/BRIEF.md
# Power-Safe Dual-Area Firmware Update Sequencer

This block controls a firmware update into a nonvolatile store that holds two code areas. The main area carries the full firmware. The recovery area carries a small update application. A request arrives marked as local or remote. The sequencer then has the image staged into a scratch buffer and waits for an external validator to pass or fail it. Only a passed image reaches the flash. The sequencer programs the two areas one after the other, through an external programming engine.

A persistent in-progress flag in the same store guards the sequence. It is written set before the first area write and written clear only after the last area write completes. At boot the sequencer reads that flag. A set flag means the previous update was cut short, so the block comes up in recovery mode. In recovery mode only local requests are served. While any flash write is under way, a halt line tells every other client to stop. Configuration data lives outside the two areas, and the sequencer never addresses it, so it survives every update.

Top module: `fw_update_seq`

## Requirements
- R1: In the first clock cycle after reset is released, the block samples `nv_flag_i`. From then on, `recovery_o` equals that sample until an update finishes or fails.
- R2: While idle in recovery mode, a request with `req_remote_i`=1 gets a one-cycle `req_nack_o`, and `status_o` becomes 4. A local request, or any request outside recovery mode, gets a one-cycle `req_ack_o` and starts an update.
- R3: An accepted request first raises `stage_en_o` until `stage_done_i`, then raises `val_req_o` until a verdict arrives. If `val_fail_i` arrives, the block returns to idle with `status_o`=2, and no flag or area write is issued.
- R4: The first write after a pass is a flag write with `flag_wdata_o`=1. The flag write with `flag_wdata_o`=0 is issued only after the recovery-area write has been acknowledged.
- R5: The main area (`prog_area_o`=1) is programmed first. The recovery area (`prog_area_o`=2) is requested only after the main write is acknowledged. A flag write and an area write are never requested together.
- R6: `prog_area_o` stays stable while `prog_req_o` is high and not yet acknowledged.
- R7: `halt_o` is high whenever a flag write or an area write is requested. It drops after the clearing flag write is acknowledged or an area write fails.
- R8: If `prog_err_i` is reported on an area write, the block returns to idle with `status_o`=3 and `recovery_o`=1, leaves the flag set, and issues no further write.
- R9: A sequence that completes returns to idle with `status_o`=1 and `recovery_o`=0.
- R10: A request that arrives while an update is busy gets neither an acknowledge nor a refusal, and it does not disturb the running sequence.
- R11: `prog_area_o` carries only the two area codes 1 and 2 while `prog_req_o` is high. The configuration region is never targeted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| nv_flag_i | input | 1 | Persistent in-progress flag as read from storage |
| req_valid_i | input | 1 | Update request strobe |
| req_remote_i | input | 1 | Request came over the network (1) or from the local host (0) |
| req_ack_o | output | 1 | One-cycle pulse: request accepted |
| req_nack_o | output | 1 | One-cycle pulse: request refused |
| stage_en_o | output | 1 | Stage the incoming image into the scratch buffer |
| stage_done_i | input | 1 | Staging finished |
| val_req_o | output | 1 | Ask the validator for a verdict |
| val_pass_i | input | 1 | Image valid |
| val_fail_i | input | 1 | Image invalid |
| flag_wr_o | output | 1 | Persistent flag write request |
| flag_wdata_o | output | 1 | Value to write into the flag |
| flag_ack_i | input | 1 | Flag write done |
| prog_req_o | output | 1 | Area program request |
| prog_area_o | output | AREA_W | Area code: 1 main, 2 recovery, 0 none |
| prog_ack_i | input | 1 | Area program done |
| prog_err_i | input | 1 | Area program failed |
| halt_o | output | 1 | Other clients must halt |
| busy_o | output | 1 | An update sequence is running |
| recovery_o | output | 1 | Recovery mode active |
| status_o | output | 3 | Last outcome: 0 none, 1 done, 2 bad image, 3 write failure, 4 refused |

## Verification
The bench builds the block with its default parameters: a 2-bit area code with 1 for the main area and 2 for the recovery area. With these values every legal area code and the unused code 0 are all reachable, and R11 can be checked by value. A responder in the bench answers the flag, area and validator handshakes with zero to two cycles of wait. The wait cycles make R6 observable, and failure injection on either area reaches both prefixes of the write order. Two reset runs, one with the stored flag clear and one with it set, reach both boot modes of R1 and the refusal path of R2.

// File: rtl/fwu_pkg.sv
package fwu_pkg;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_DONE    = 3'd1,
        ST_BADIMG  = 3'd2,
        ST_WRFAIL  = 3'd3,
        ST_REFUSED = 3'd4
    } seq_status_e;

    typedef enum logic [3:0] {
        S_BOOT,
        S_IDLE,
        S_STAGE,
        S_CHECK,
        S_MARK,
        S_WR_MAIN,
        S_WR_REC,
        S_UNMARK
    } seq_state_e;

    typedef struct packed {
        seq_state_e  state;
        logic        recovery;
        seq_status_e status;
    } seq_regs_t;

    typedef struct packed {
        logic ack;
        logic nack;
    } gate_regs_t;

endpackage

// File: rtl/fwu_req_gate.sv
module fwu_req_gate
    import fwu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_i,
    input  logic recovery_i,
    input  logic req_valid_i,
    input  logic req_remote_i,
    output logic accept_o,
    output logic reject_o,
    output logic ack_o,
    output logic nack_o
);

    gate_regs_t gate_d, gate_q;
    logic       remote_blocked;

    always_comb begin
        remote_blocked = recovery_i && req_remote_i;
        accept_o       = idle_i && req_valid_i && !remote_blocked;
        reject_o       = idle_i && req_valid_i && remote_blocked;
        gate_d         = gate_q;
        gate_d.ack     = accept_o;
        gate_d.nack    = reject_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= '0;
        end else begin
            gate_q <= gate_d;
        end
    end

    assign ack_o  = gate_q.ack;
    assign nack_o = gate_q.nack;

    // R2
    remote_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && req_valid_i && req_remote_i && recovery_i) |=> (nack_o && !ack_o));

    // R10
    busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_i) |=> (!ack_o && !nack_o));

endmodule

// File: rtl/fwu_seq_fsm.sv
module fwu_seq_fsm
    import fwu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nv_flag_i,
    input  logic        accept_i,
    input  logic        reject_i,
    input  logic        stage_done_i,
    input  logic        val_pass_i,
    input  logic        val_fail_i,
    input  logic        flag_ack_i,
    input  logic        prog_ack_i,
    input  logic        prog_err_i,
    output logic        idle_o,
    output logic        stage_en_o,
    output logic        val_req_o,
    output logic        flag_wr_o,
    output logic        flag_wdata_o,
    output logic        wr_main_o,
    output logic        wr_rec_o,
    output logic        halt_o,
    output logic        busy_o,
    output logic        recovery_o,
    output seq_status_e status_o
);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            S_BOOT: begin
                seq_d.recovery = nv_flag_i;
                seq_d.state    = S_IDLE;
            end
            S_IDLE: begin
                if (accept_i) begin
                    seq_d.state  = S_STAGE;
                    seq_d.status = ST_NONE;
                end else if (reject_i) begin
                    seq_d.status = ST_REFUSED;
                end
            end
            S_STAGE: begin
                if (stage_done_i) seq_d.state = S_CHECK;
            end
            S_CHECK: begin
                if (val_fail_i) begin
                    seq_d.state  = S_IDLE;
                    seq_d.status = ST_BADIMG;
                end else if (val_pass_i) begin
                    seq_d.state = S_MARK;
                end
            end
            S_MARK: begin
                if (flag_ack_i) seq_d.state = S_WR_MAIN;
            end
            S_WR_MAIN: begin
                if (prog_err_i) begin
                    seq_d.state    = S_IDLE;
                    seq_d.status   = ST_WRFAIL;
                    seq_d.recovery = 1'b1;
                end else if (prog_ack_i) begin
                    seq_d.state = S_WR_REC;
                end
            end
            S_WR_REC: begin
                if (prog_err_i) begin
                    seq_d.state    = S_IDLE;
                    seq_d.status   = ST_WRFAIL;
                    seq_d.recovery = 1'b1;
                end else if (prog_ack_i) begin
                    seq_d.state = S_UNMARK;
                end
            end
            S_UNMARK: begin
                if (flag_ack_i) begin
                    seq_d.state    = S_IDLE;
                    seq_d.status   = ST_DONE;
                    seq_d.recovery = 1'b0;
                end
            end
            default: seq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state    <= S_BOOT;
            seq_q.recovery <= 1'b0;
            seq_q.status   <= ST_NONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        idle_o       = (seq_q.state == S_IDLE);
        stage_en_o   = (seq_q.state == S_STAGE);
        val_req_o    = (seq_q.state == S_CHECK);
        flag_wr_o    = (seq_q.state == S_MARK) || (seq_q.state == S_UNMARK);
        flag_wdata_o = (seq_q.state == S_MARK);
        wr_main_o    = (seq_q.state == S_WR_MAIN);
        wr_rec_o     = (seq_q.state == S_WR_REC);
        halt_o       = flag_wr_o || wr_main_o || wr_rec_o;
        busy_o       = halt_o || stage_en_o || val_req_o;
        recovery_o   = seq_q.recovery;
        status_o     = seq_q.status;
    end

    // R3
    write_after_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_o && flag_wdata_o && !$past(flag_wr_o)) |-> $past(val_req_o && val_pass_i));

    // R3
    fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (val_req_o && val_fail_i) |=> (!flag_wr_o && !wr_main_o && idle_o));

    // R4
    clear_after_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_o && !flag_wdata_o && !$past(flag_wr_o)) |-> $past(wr_rec_o && prog_ack_i));

    // R8
    abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_main_o || wr_rec_o) && prog_err_i) |=> (!flag_wr_o && !wr_main_o && !wr_rec_o && recovery_o));

endmodule

// File: rtl/fwu_prog_port.sv
module fwu_prog_port #(
    parameter int unsigned             AREA_W  = 2,
    parameter logic [AREA_W-1:0]       NONE_ID = '0,
    parameter logic [AREA_W-1:0]       MAIN_ID = 1,
    parameter logic [AREA_W-1:0]       REC_ID  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_main_i,
    input  logic              wr_rec_i,
    input  logic              flag_wr_i,
    input  logic              prog_ack_i,
    output logic              prog_req_o,
    output logic [AREA_W-1:0] prog_area_o
);

    localparam int unsigned AREA_CODES = 1 << AREA_W;

    always_comb begin
        prog_req_o  = wr_main_i || wr_rec_i;
        prog_area_o = NONE_ID;
        if (wr_main_i)     prog_area_o = MAIN_ID;
        else if (wr_rec_i) prog_area_o = REC_ID;
    end

    initial begin
        assert (AREA_CODES >= 3 && MAIN_ID != REC_ID && MAIN_ID != NONE_ID && REC_ID != NONE_ID)
            else $error("area codes must be distinct and fit AREA_W");
    end

    // R5
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req_o && flag_wr_i));

    // R5
    rec_after_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_o && prog_area_o == REC_ID && !$past(prog_req_o && prog_area_o == REC_ID))
        |-> $past(prog_req_o && prog_area_o == MAIN_ID && prog_ack_i));

    // R6
    area_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_o && !prog_ack_i) |=> (!prog_req_o || $stable(prog_area_o)));

    // R11
    legal_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> (prog_area_o == MAIN_ID || prog_area_o == REC_ID));

endmodule

// File: rtl/fw_update_seq.sv
module fw_update_seq
    import fwu_pkg::*;
#(
    parameter int unsigned       AREA_W  = 2,
    parameter logic [AREA_W-1:0] MAIN_ID = 1,
    parameter logic [AREA_W-1:0] REC_ID  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nv_flag_i,
    input  logic              req_valid_i,
    input  logic              req_remote_i,
    output logic              req_ack_o,
    output logic              req_nack_o,
    output logic              stage_en_o,
    input  logic              stage_done_i,
    output logic              val_req_o,
    input  logic              val_pass_i,
    input  logic              val_fail_i,
    output logic              flag_wr_o,
    output logic              flag_wdata_o,
    input  logic              flag_ack_i,
    output logic              prog_req_o,
    output logic [AREA_W-1:0] prog_area_o,
    input  logic              prog_ack_i,
    input  logic              prog_err_i,
    output logic              halt_o,
    output logic              busy_o,
    output logic              recovery_o,
    output logic [2:0]        status_o
);

    logic        idle, accept, reject, wr_main, wr_rec;
    seq_status_e status;

    fwu_req_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .idle_i       (idle),
        .recovery_i   (recovery_o),
        .req_valid_i  (req_valid_i),
        .req_remote_i (req_remote_i),
        .accept_o     (accept),
        .reject_o     (reject),
        .ack_o        (req_ack_o),
        .nack_o       (req_nack_o)
    );

    fwu_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .nv_flag_i    (nv_flag_i),
        .accept_i     (accept),
        .reject_i     (reject),
        .stage_done_i (stage_done_i),
        .val_pass_i   (val_pass_i),
        .val_fail_i   (val_fail_i),
        .flag_ack_i   (flag_ack_i),
        .prog_ack_i   (prog_ack_i),
        .prog_err_i   (prog_err_i),
        .idle_o       (idle),
        .stage_en_o   (stage_en_o),
        .val_req_o    (val_req_o),
        .flag_wr_o    (flag_wr_o),
        .flag_wdata_o (flag_wdata_o),
        .wr_main_o    (wr_main),
        .wr_rec_o     (wr_rec),
        .halt_o       (halt_o),
        .busy_o       (busy_o),
        .recovery_o   (recovery_o),
        .status_o     (status)
    );

    fwu_prog_port #(
        .AREA_W  (AREA_W),
        .NONE_ID ('0),
        .MAIN_ID (MAIN_ID),
        .REC_ID  (REC_ID)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_main_i   (wr_main),
        .wr_rec_i    (wr_rec),
        .flag_wr_i   (flag_wr_o),
        .prog_ack_i  (prog_ack_i),
        .prog_req_o  (prog_req_o),
        .prog_area_o (prog_area_o)
    );

    assign status_o = status;

    // R7
    halt_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req_o || flag_wr_o) |-> halt_o);

    // R7
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr_o && !flag_wdata_o && flag_ack_i) |=> !halt_o);

endmodule

// File: tb/fw_update_seq_test.sv
module fw_update_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_flag_i = 1'b0;
    logic       req_valid_i = 1'b0;
    logic       req_remote_i = 1'b0;
    logic       stage_done_i = 1'b0;
    logic       val_pass_i = 1'b0;
    logic       val_fail_i = 1'b0;
    logic       flag_ack_i = 1'b0;
    logic       prog_ack_i = 1'b0;
    logic       prog_err_i = 1'b0;
    logic       req_ack_o, req_nack_o, stage_en_o, val_req_o;
    logic       flag_wr_o, flag_wdata_o, prog_req_o;
    logic [1:0] prog_area_o;
    logic       halt_o, busy_o, recovery_o;
    logic [2:0] status_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fw_update_seq uut (
        .clk(clk), .rst_n(rst_n), .nv_flag_i(nv_flag_i),
        .req_valid_i(req_valid_i), .req_remote_i(req_remote_i),
        .req_ack_o(req_ack_o), .req_nack_o(req_nack_o),
        .stage_en_o(stage_en_o), .stage_done_i(stage_done_i),
        .val_req_o(val_req_o), .val_pass_i(val_pass_i), .val_fail_i(val_fail_i),
        .flag_wr_o(flag_wr_o), .flag_wdata_o(flag_wdata_o), .flag_ack_i(flag_ack_i),
        .prog_req_o(prog_req_o), .prog_area_o(prog_area_o),
        .prog_ack_i(prog_ack_i), .prog_err_i(prog_err_i),
        .halt_o(halt_o), .busy_o(busy_o), .recovery_o(recovery_o), .status_o(status_o)
    );

    typedef struct packed {
        logic       remote;
        logic       vpass;
        logic [1:0] failat;
        logic [1:0] lat;
        logic       inject;
        logic [2:0] st;
        logic [2:0] nops;
        logic       rec;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd0, 2'd0, 1'b0, 3'd1, 3'd4, 1'b0},
        '{1'b1, 1'b1, 2'd0, 2'd2, 1'b1, 3'd1, 3'd4, 1'b0},
        '{1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 3'd2, 3'd0, 1'b0},
        '{1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 3'd3, 3'd2, 1'b1},
        '{1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 3'd4, 3'd0, 1'b1},
        '{1'b0, 1'b1, 2'd2, 2'd2, 1'b0, 3'd3, 3'd3, 1'b1},
        '{1'b0, 1'b0, 2'd0, 2'd1, 1'b1, 3'd2, 3'd0, 1'b1},
        '{1'b0, 1'b1, 2'd0, 2'd1, 1'b0, 3'd1, 3'd4, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_resp();
        stage_done_i = 1'b0; val_pass_i = 1'b0; val_fail_i = 1'b0;
        flag_ack_i = 1'b0; prog_ack_i = 1'b0; prog_err_i = 1'b0;
    endtask

    task automatic run_vec(input vec_t v);
        int ops [8];
        int nops = 0;
        int wcnt = 0;
        int last_area = -1;
        bit injected = 1'b0;
        bit check_next = 1'b0;
        bit seq_ok = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b1; req_remote_i = v.remote;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (v.st == 3'd4) begin
            check(req_nack_o && !req_ack_o, "R2 refusal pulse", int'(req_nack_o), 1);
            check(!busy_o && !stage_en_o, "R2 refused request does not stage", int'(busy_o), 0);
        end else begin
            check(req_ack_o && !req_nack_o, "R2 accept pulse", int'(req_ack_o), 1);
        end
        for (int c = 0; c < 200; c++) begin
            clear_resp();
            if (check_next) begin
                req_valid_i = 1'b0;
                check(!req_ack_o && !req_nack_o, "R10 busy request ignored",
                      int'(req_ack_o | req_nack_o), 0);
                check_next = 1'b0;
            end
            if (!busy_o) break;
            if (prog_req_o && flag_wr_o)
                check(1'b0, "R5 flag and area write together", 1, 0);
            if ((prog_req_o || flag_wr_o) && !halt_o)
                check(1'b0, "R7 halt during write", int'(halt_o), 1);
            if (stage_en_o) begin
                stage_done_i = 1'b1;
                if (v.inject && !injected) begin
                    req_valid_i = 1'b1; req_remote_i = 1'b0;
                    injected = 1'b1; check_next = 1'b1;
                end
            end
            if (val_req_o) begin
                val_pass_i = v.vpass;
                val_fail_i = !v.vpass;
            end
            if (flag_wr_o) begin
                if (wcnt == int'(v.lat)) begin
                    if (nops < 8) ops[nops] = flag_wdata_o ? 1 : 4;
                    nops++;
                    flag_ack_i = 1'b1;
                    wcnt = 0;
                end else wcnt++;
            end
            if (prog_req_o) begin
                if (prog_area_o != 2'd1 && prog_area_o != 2'd2)
                    check(1'b0, "R11 illegal area code", int'(prog_area_o), 1);
                if (wcnt > 0 && last_area != int'(prog_area_o))
                    check(1'b0, "R6 area changed while pending", int'(prog_area_o), last_area);
                last_area = int'(prog_area_o);
                if (wcnt == int'(v.lat)) begin
                    if (nops < 8) ops[nops] = int'(prog_area_o) + 1;
                    nops++;
                    if (int'(v.failat) == int'(prog_area_o)) prog_err_i = 1'b1;
                    else prog_ack_i = 1'b1;
                    wcnt = 0;
                end else wcnt++;
            end
            @(negedge clk);
        end
        clear_resp();
        req_valid_i = 1'b0;
        check(!busy_o && !halt_o, "R7 halt released at end", int'(halt_o), 0);
        check(status_o == v.st, "R3/R8/R9 final status", int'(status_o), int'(v.st));
        check(recovery_o == v.rec, "R8/R9 recovery mode after update", int'(recovery_o), int'(v.rec));
        check(nops == int'(v.nops), "R3/R4 number of writes", nops, int'(v.nops));
        for (int k = 0; k < nops && k < 8; k++)
            if (ops[k] != k + 1) seq_ok = 1'b0;
        check(seq_ok, "R4/R5 write order flag-set, main, recovery, flag-clear", int'(seq_ok), 1);
    endtask

    task automatic do_reset(input logic flag);
        rst_n = 1'b0; nv_flag_i = flag;
        repeat (3) @(negedge clk);
        check(!busy_o && !halt_o && !prog_req_o && !flag_wr_o && status_o == 3'd0,
              "R1 reset state idle", int'(status_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        nv_flag_i = 1'b0;
        @(negedge clk);
        check(recovery_o == flag, "R1 boot mode from stored flag", int'(recovery_o), int'(flag));
    endtask

    initial begin
        do_reset(1'b0);
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        // R1 / R2: boot with the flag set, remote refused, local repairs
        do_reset(1'b1);
        run_vec('{1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 3'd4, 3'd0, 1'b1});
        run_vec('{1'b0, 1'b1, 2'd0, 2'd0, 1'b1, 3'd1, 3'd4, 1'b0});
        // R9: back in normal mode, remote works again
        run_vec('{1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 3'd1, 3'd4, 1'b0});
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule